// File: doc/BRIEF.md
# Critical Section Request Buffer

This block sits between a group of small cores and one large core that executes critical sections for them. A small core that reaches a critical section hands over a call request: the lock address, the entry PC of the section, its stack pointer and its own core number. Accepted requests wait in a first-in first-out queue and go to the large core one at a time. The large core takes the lock, runs the section and frees the lock before it reports completion. The buffer keeps the owner of the section in flight, so a completion pulse reaches that core without a core number on the completion input.

A shared queue can put sections guarded by unrelated locks behind each other, which serializes them for no reason. A table of 2-bit saturating counters, indexed by the low lock-address bits, tracks how often this happens for each lock. When a counter reaches its upper half, new requests for that lock are no longer queued. The caller gets an immediate run-locally response instead.

Top module: `cs_request_buffer`

## Requirements
- R1: After reset the queue is empty and the table holds all zeros. `dispValid`, `localVec` and `doneVec` are 0 and `reqReady` is 1.
- R2: Queued requests reach the large core in arrival order. The dispatch outputs carry the lock, PC, stack pointer and core number of the request at the head of the queue, unchanged.
- R3: A request is popped in a cycle where `dispValid` and `dispReady` are both 1. After a pop, `dispValid` stays 0 until a completion has been taken, so only one section is in flight at a time.
- R4: When `doneIn` is 1 while a section is in flight, `doneVec` is the one-hot code of that section's core (bit n = core n) in the next cycle, for exactly one cycle. A `doneIn` pulse while nothing is in flight leaves `doneVec` at 0.
- R5: With DEPTH entries queued and no pop in the same cycle, `reqReady` is 0. A held request is kept waiting and is not lost.
- R6: On a full queue, a request and a pop in the same cycle are both accepted. The new request joins the tail behind the remaining entries.
- R7: At each pop, the table counter for the popped lock goes up by one if any other queued entry, not counting the popped one or a request pushed in the same cycle, has a different lock address. Otherwise it goes down by one. It saturates at 0 and at 3.
- R8: A request whose counter has bit 1 set, read before any update in the same cycle, is accepted but not queued. `localVec` is then the one-hot code of its core in the next cycle, for one cycle.
- R9: The table is indexed by lock address bits [3:0], so locks that agree in those bits share one counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A small core offers a request |
| reqReady | output | 1 | The buffer takes the offered request this cycle |
| reqLock | input | LOCK_W | Lock address of the request |
| reqTarget | input | PC_W | Entry PC of the critical section |
| reqStack | input | PC_W | Caller stack pointer |
| reqCore | input | CORE_W | Number of the requesting core |
| dispValid | output | 1 | Head request offered to the large core |
| dispReady | input | 1 | The large core takes the head request |
| dispLock | output | LOCK_W | Lock address of the head request |
| dispTarget | output | PC_W | Entry PC of the head request |
| dispStack | output | PC_W | Stack pointer of the head request |
| dispCore | output | CORE_W | Core number of the head request |
| doneIn | input | 1 | The large core has finished and released the lock |
| doneVec | output | NUM_CORES | One-hot completion to the owning core |
| localVec | output | NUM_CORES | One-hot run-locally response |

## Verification
The dispatch outputs and `reqReady` follow the queue state in the same cycle, so they are compared half a cycle after the inputs change, before the edge that would act on them. `localVec` and `doneVec` are registered, so each is compared at the falling edge one cycle after the edge where the request or `doneIn` was taken. A pop updates its counter at the same edge, so the effect of a counter change can first be seen on a request taken at a later edge. The bench keeps its own queue and counter model to predict each pop, and it predicts each local or queued decision from that model or from its vector table.

// File: rtl/csrb_pkg.sv
package csrb_pkg;
  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic push;    // store the offered request at the tail
    logic pop;     // hand the head to the large core
    logic goLocal; // answer the offered request with run-locally
    logic doneEn;  // completion of the section in flight
  } csrbStrobes_t;
endpackage

// File: rtl/csrb_control.sv
module csrb_control
  import csrb_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             dispReady,
  input  logic             doneIn,
  input  logic             predictLocal,
  output logic             reqReady,
  output logic             dispValid,
  output logic [CNT_W-1:0] count,
  output csrbStrobes_t     strobes
);
  logic busy;
  logic isEmpty;
  logic isFull;
  logic popFire;
  logic accept;

  assign isEmpty   = (count == '0);
  assign isFull    = (count == CNT_W'(DEPTH));
  assign dispValid = !isEmpty && !busy;
  assign popFire   = dispValid && dispReady;
  assign reqReady  = !isFull || popFire;
  assign accept    = reqValid && reqReady;

  always_comb begin
    strobes.push    = accept && !predictLocal;
    strobes.goLocal = accept && predictLocal;
    strobes.pop     = popFire;
    strobes.doneEn  = doneIn && busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      busy  <= 1'b0;
    end else begin
      count <= count + CNT_W'(strobes.push) - CNT_W'(strobes.pop);
      if (strobes.pop)         busy <= 1'b1;
      else if (strobes.doneEn) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/csrb_datapath.sv
module csrb_datapath
  import csrb_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int NUM_CORES   = 28,
  parameter int LOCK_W      = 32,
  parameter int PC_W        = 32,
  parameter int TBL_ENTRIES = 16,
  parameter int CTR_W       = 2,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int CORE_W = $clog2(NUM_CORES),
  localparam int IDX_W  = $clog2(TBL_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  csrbStrobes_t         strobes,
  input  logic [CNT_W-1:0]     count,
  input  logic [LOCK_W-1:0]    reqLock,
  input  logic [PC_W-1:0]      reqTarget,
  input  logic [PC_W-1:0]      reqStack,
  input  logic [CORE_W-1:0]    reqCore,
  output logic                 predictLocal,
  output logic [LOCK_W-1:0]    dispLock,
  output logic [PC_W-1:0]      dispTarget,
  output logic [PC_W-1:0]      dispStack,
  output logic [CORE_W-1:0]    dispCore,
  output logic [NUM_CORES-1:0] doneVec,
  output logic [NUM_CORES-1:0] localVec
);
  localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};

  logic [LOCK_W-1:0] lockMem [DEPTH];
  logic [PC_W-1:0]   tgtMem  [DEPTH];
  logic [PC_W-1:0]   spMem   [DEPTH];
  logic [CORE_W-1:0] coreMem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [CTR_W-1:0]  ctrTbl [TBL_ENTRIES];
  logic [CORE_W-1:0] owner;
  logic [DEPTH-1:0]  diffVec;
  logic              otherLock;
  logic [IDX_W-1:0]  popIdx;
  logic [NUM_CORES-1:0] reqOneHot;
  logic [NUM_CORES-1:0] ownerOneHot;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Head of the queue, seen by the large core.
  assign dispLock   = lockMem[rdPtr];
  assign dispTarget = tgtMem[rdPtr];
  assign dispStack  = spMem[rdPtr];
  assign dispCore   = coreMem[rdPtr];

  // Find waiting entries (not the head) that guard another lock.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [PTR_W:0] rawOfs;
    logic [PTR_W:0] ofs;
    assign rawOfs = {1'b0, PTR_W'(i)} + (PTR_W + 1)'(DEPTH) - {1'b0, rdPtr};
    assign ofs    = (rawOfs >= (PTR_W + 1)'(DEPTH)) ? rawOfs - (PTR_W + 1)'(DEPTH) : rawOfs;
    assign diffVec[i] = (ofs != '0) && (ofs < (PTR_W + 1)'(count)) &&
                        (lockMem[i] != dispLock);
  end
  assign otherLock = |diffVec;

  assign popIdx       = dispLock[IDX_W-1:0];
  assign predictLocal = ctrTbl[reqLock[IDX_W-1:0]][CTR_W-1];

  // Storage and pointers.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.push) begin
        lockMem[wrPtr] <= reqLock;
        tgtMem[wrPtr]  <= reqTarget;
        spMem[wrPtr]   <= reqStack;
        coreMem[wrPtr] <= reqCore;
        wrPtr          <= nextPtr(wrPtr);
      end
      if (strobes.pop) rdPtr <= nextPtr(rdPtr);
    end
  end

  // Saturating counters that track false serialization.
  for (genvar t = 0; t < TBL_ENTRIES; t++) begin : g_ctr
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ctrTbl[t] <= '0;
      end else if (strobes.pop && popIdx == IDX_W'(t)) begin
        if (otherLock && ctrTbl[t] != CTR_MAX)      ctrTbl[t] <= ctrTbl[t] + 1'b1;
        else if (!otherLock && ctrTbl[t] != '0)     ctrTbl[t] <= ctrTbl[t] - 1'b1;
      end
    end
  end

  // One-hot decode of the core numbers used for responses.
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_dec
    assign reqOneHot[c]   = (reqCore == CORE_W'(c));
    assign ownerOneHot[c] = (owner == CORE_W'(c));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      owner    <= '0;
      doneVec  <= '0;
      localVec <= '0;
    end else begin
      if (strobes.pop) owner <= dispCore;
      doneVec  <= strobes.doneEn  ? ownerOneHot : '0;
      localVec <= strobes.goLocal ? reqOneHot   : '0;
    end
  end
endmodule

// File: rtl/cs_request_buffer.sv
module cs_request_buffer
  import csrb_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int NUM_CORES   = 28,
  parameter int LOCK_W      = 32,
  parameter int PC_W        = 32,
  parameter int TBL_ENTRIES = 16,
  parameter int CTR_W       = 2,
  localparam int CORE_W = $clog2(NUM_CORES),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [LOCK_W-1:0]    reqLock,
  input  logic [PC_W-1:0]      reqTarget,
  input  logic [PC_W-1:0]      reqStack,
  input  logic [CORE_W-1:0]    reqCore,
  output logic                 dispValid,
  input  logic                 dispReady,
  output logic [LOCK_W-1:0]    dispLock,
  output logic [PC_W-1:0]      dispTarget,
  output logic [PC_W-1:0]      dispStack,
  output logic [CORE_W-1:0]    dispCore,
  input  logic                 doneIn,
  output logic [NUM_CORES-1:0] doneVec,
  output logic [NUM_CORES-1:0] localVec
);
  csrbStrobes_t     strobes;
  logic [CNT_W-1:0] fifoCount;
  logic             predictLocal;

  csrb_control #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .dispReady(dispReady),
    .doneIn(doneIn), .predictLocal(predictLocal), .reqReady(reqReady),
    .dispValid(dispValid), .count(fifoCount), .strobes(strobes)
  );

  csrb_datapath #(
    .DEPTH(DEPTH), .NUM_CORES(NUM_CORES), .LOCK_W(LOCK_W), .PC_W(PC_W),
    .TBL_ENTRIES(TBL_ENTRIES), .CTR_W(CTR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .count(fifoCount),
    .reqLock(reqLock), .reqTarget(reqTarget), .reqStack(reqStack),
    .reqCore(reqCore), .predictLocal(predictLocal), .dispLock(dispLock),
    .dispTarget(dispTarget), .dispStack(dispStack), .dispCore(dispCore),
    .doneVec(doneVec), .localVec(localVec)
  );
endmodule

// File: rtl/cs_request_buffer_checker.sv
module cs_request_buffer_checker #(
  parameter int DEPTH     = 8,
  parameter int NUM_CORES = 28,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqReady,
  input logic                 dispValid,
  input logic                 dispReady,
  input logic                 doneIn,
  input logic [NUM_CORES-1:0] doneVec,
  input logic [NUM_CORES-1:0] localVec,
  input logic [CNT_W-1:0]     count
);
  a_r3_single_flight: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && dispReady) |=> !dispValid);

  a_r5_full_stall: assert property (@(posedge clk) disable iff (!rstN)
    (count == CNT_W'(DEPTH) && !(dispValid && dispReady)) |-> !reqReady);

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  a_r2_valid_needs_entry: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |-> (count != '0));

  a_r4_done_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(doneVec));

  a_r4_done_cause: assert property (@(posedge clk) disable iff (!rstN)
    (doneVec != '0) |-> $past(doneIn));

  a_r8_local_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(localVec));

  a_r8_local_cause: assert property (@(posedge clk) disable iff (!rstN)
    (localVec != '0) |-> $past(reqValid && reqReady));
endmodule

bind cs_request_buffer cs_request_buffer_checker #(
  .DEPTH(DEPTH), .NUM_CORES(NUM_CORES)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .dispValid(dispValid), .dispReady(dispReady), .doneIn(doneIn),
  .doneVec(doneVec), .localVec(localVec), .count(fifoCount)
);

// File: tb/cs_request_buffer_bench.sv
module cs_request_buffer_bench;
  localparam int DEPTH = 8;
  localparam int NC    = 28;

  typedef struct packed {
    logic [31:0] lock;
    logic [31:0] tpc;
    logic [31:0] sp;
    logic [4:0]  core;
    logic        expLocal;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0000_0100, 32'h4000_0010, 32'h7FF0_0000, 5'd3,  1'b0},
    '{32'h0000_0204, 32'h4000_0020, 32'h7FE0_0000, 5'd27, 1'b0},
    '{32'h0000_0100, 32'h4000_0030, 32'h7FD0_0000, 5'd0,  1'b0},
    '{32'h0000_03A7, 32'h4000_0040, 32'h7FC0_0000, 5'd14, 1'b0},
    '{32'h0000_0555, 32'h4000_0050, 32'h7FB0_0000, 5'd9,  1'b0},
    '{32'h0000_0204, 32'h4000_0060, 32'h7FA0_0000, 5'd21, 1'b0}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, dispReady = 1'b0, doneIn = 1'b0;
  logic [31:0] reqLock = '0, reqTarget = '0, reqStack = '0;
  logic [4:0]  reqCore = '0;
  logic reqReady, dispValid;
  logic [31:0] dispLock, dispTarget, dispStack;
  logic [4:0]  dispCore;
  logic [NC-1:0] doneVec, localVec;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // Bench model of the queue and counters.
  logic [31:0] mLock [64];
  logic [31:0] mTpc  [64];
  logic [31:0] mSp   [64];
  logic [4:0]  mCore [64];
  int mHead = 0, mTail = 0;
  int mCtr [16];
  logic [4:0] inFlight;

  always #2 clk = ~clk;

  cs_request_buffer u_cs_request_buffer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqLock(reqLock), .reqTarget(reqTarget), .reqStack(reqStack),
    .reqCore(reqCore), .dispValid(dispValid), .dispReady(dispReady),
    .dispLock(dispLock), .dispTarget(dispTarget), .dispStack(dispStack),
    .dispCore(dispCore), .doneIn(doneIn), .doneVec(doneVec), .localVec(localVec)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] oneHot(input logic [4:0] c);
    return NC'(1) << c;
  endfunction

  function automatic bit modelLocal(input logic [31:0] lock);
    return mCtr[lock[3:0]] >= 2;
  endfunction

  // Called at a falling edge, returns at a falling edge.
  task automatic pushReq(input logic [31:0] lock, input logic [31:0] tpc,
                         input logic [31:0] sp, input logic [4:0] core,
                         input bit expLocal, input string req);
    reqValid = 1; reqLock = lock; reqTarget = tpc; reqStack = sp; reqCore = core;
    #1;
    check(reqReady == 1'b1, "R5", "ready with space", 128'(reqReady), 128'(1));
    @(posedge clk); @(negedge clk);
    reqValid = 0;
    check(localVec == (expLocal ? oneHot(core) : '0), req, "local response",
          128'(localVec), 128'(expLocal ? oneHot(core) : '0));
    if (!expLocal) begin
      mLock[mTail % 64] = lock; mTpc[mTail % 64] = tpc;
      mSp[mTail % 64] = sp; mCore[mTail % 64] = core; mTail++;
    end
  endtask

  task automatic modelPop();
    bit other = 0;
    for (int k = mHead + 1; k < mTail; k++)
      if (mLock[k % 64] != mLock[mHead % 64]) other = 1;
    if (other && mCtr[mLock[mHead % 64][3:0]] < 3) mCtr[mLock[mHead % 64][3:0]]++;
    else if (!other && mCtr[mLock[mHead % 64][3:0]] > 0) mCtr[mLock[mHead % 64][3:0]]--;
    inFlight = mCore[mHead % 64];
    mHead++;
  endtask

  task automatic dispatch();
    int h = mHead % 64;
    check(dispValid == 1'b1, "R2", "head offered", 128'(dispValid), 128'(1));
    check({dispLock, dispTarget, dispStack, dispCore} ==
          {mLock[h], mTpc[h], mSp[h], mCore[h]}, "R2", "head fields",
          128'({dispLock, dispTarget, dispStack, dispCore}),
          128'({mLock[h], mTpc[h], mSp[h], mCore[h]}));
    dispReady = 1;
    @(posedge clk); @(negedge clk);
    dispReady = 0;
    modelPop();
    check(dispValid == 1'b0, "R3", "no second dispatch in flight", 128'(dispValid), 128'(0));
  endtask

  task automatic finishSection();
    doneIn = 1;
    @(posedge clk); @(negedge clk);
    doneIn = 0;
    check(doneVec == oneHot(inFlight), "R4", "completion routed",
          128'(doneVec), 128'(oneHot(inFlight)));
    @(posedge clk); @(negedge clk);
    check(doneVec == '0, "R4", "completion lasts one cycle", 128'(doneVec), 128'(0));
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    check(1'b0, "WATCHDOG", "run did not end", 128'(0), 128'(1));
    finishRun();
  end

  initial begin
    for (int i = 0; i < 16; i++) mCtr[i] = 0;
    inFlight = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R1: reset state
    check(reqReady == 1 && dispValid == 0, "R1", "handshake after reset",
          128'({reqReady, dispValid}), 128'(2'b10));
    check(doneVec == '0 && localVec == '0, "R1", "responses after reset",
          128'({doneVec, localVec}), 128'(0));

    // Vector table: push all, then dispatch and complete in order (R2, R4, R7).
    for (int v = 0; v < 6; v++)
      pushReq(VECS[v].lock, VECS[v].tpc, VECS[v].sp, VECS[v].core, VECS[v].expLocal, "R8");
    for (int v = 0; v < 6; v++) begin
      dispatch();
      finishSection();
    end
    // R7: counter of index 0 reached 2 through two false-serialization pops.
    check(mCtr[0] == 2, "R7", "model counter index 0", 128'(mCtr[0]), 128'(2));
    // R9: an alias of index 0 is sent to run locally.
    pushReq(32'h0000_00A0, 32'h4000_0070, 32'h7F90_0000, 5'd5, 1'b1, "R9");

    // R4: completion while idle is ignored.
    doneIn = 1;
    @(posedge clk); @(negedge clk);
    doneIn = 0;
    check(doneVec == '0, "R4", "idle completion ignored", 128'(doneVec), 128'(0));

    // R5 / R6: fill, stall, then push and pop together.
    for (int k = 0; k < DEPTH; k++)
      pushReq(32'h0000_000F, 32'h5000_0000 + 32'(k), 32'h6000_0000 + 32'(k),
              5'(k + 10), 1'b0, "R8");
    reqValid = 1; reqLock = 32'h0000_000F; reqTarget = 32'h5000_00FF;
    reqStack = 32'h6000_00FF; reqCore = 5'd1;
    #1;
    check(reqReady == 0, "R5", "full stalls request", 128'(reqReady), 128'(0));
    @(posedge clk); @(negedge clk);
    check(reqReady == 0, "R5", "request still held", 128'(reqReady), 128'(0));
    dispReady = 1;
    #1;
    check(reqReady == 1, "R6", "pop frees slot same cycle", 128'(reqReady), 128'(1));
    @(posedge clk); @(negedge clk);
    reqValid = 0; dispReady = 0;
    modelPop();
    mLock[mTail % 64] = 32'h0000_000F; mTpc[mTail % 64] = 32'h5000_00FF;
    mSp[mTail % 64] = 32'h6000_00FF; mCore[mTail % 64] = 5'd1; mTail++;
    check(localVec == '0, "R6", "simultaneous push queued", 128'(localVec), 128'(0));
    finishSection();
    for (int k = 0; k < DEPTH; k++) begin
      dispatch();
      finishSection();
    end

    // R7 saturation: four pops of lock 1 with lock 2 waiting behind.
    for (int k = 0; k < 4; k++)
      pushReq(32'h0000_0001, 32'h4100_0000 + 32'(k), 32'h7000_0000, 5'(k), 1'b0, "R8");
    pushReq(32'h0000_0002, 32'h4200_0000, 32'h7100_0000, 5'd20, 1'b0, "R8");
    for (int k = 0; k < 5; k++) begin
      dispatch();
      finishSection();
    end
    check(mCtr[1] == 3 && mCtr[2] == 0, "R7", "model saturates",
          128'({mCtr[1], mCtr[2]}), 128'({32'd3, 32'd0}));
    pushReq(32'h0000_0001, 32'h4100_0010, 32'h7000_0010, 5'd6, modelLocal(32'h1), "R7");
    pushReq(32'h0000_0011, 32'h4100_0020, 32'h7000_0020, 5'd7, 1'b1, "R9");
    pushReq(32'h0000_0002, 32'h4200_0010, 32'h7100_0010, 5'd8, 1'b0, "R7");
    dispatch();
    finishSection();
    check(dispValid == 0, "R1", "queue drained", 128'(dispValid), 128'(0));
    finishRun();
  end
endmodule